// File: doc/BRIEF.md
# Multicycle Processor Control with Register Swap and Three-Operand Add

This block is the sequencing core of a small multicycle load/store processor. A Moore state machine steers one ALU, one shared memory port and a register file with two read ports and one write port. The working registers it steers are the instruction register, the operand latches A and B, the ALU result latch and a memory data latch. The core runs register-register arithmetic, word loads and stores, branch-on-equal and an absolute jump. It adds two operations on top of these. The first exchanges the contents of two registers. The second writes the sum of three registers.

The register file stays a plain two-read, one-write array. The exchange uses the A and B latches as write-back sources and spends two write-back cycles. The three-operand add spends two execute cycles. In the first, B is reloaded through read port 2, which is addressed by a fourth register field. In the second, the ALU result latch is fed back as the first ALU operand. Memory is external: the core drives an address, a read strobe, a write strobe and write data, and expects read data back in the same cycle. The register write port is also brought out so that its activity can be observed.

Top module: `mc_core`

## Requirements
- R1: While `rst` is high, neither memory nor the register file is written. In the first cycle after `rst` falls, the core issues an instruction fetch (read strobe high) from address 0.
- R2: Every instruction begins with a fetch cycle that reads memory at the PC and advances the PC by 4. A decode cycle always follows. After its last cycle, every instruction returns to fetch.
- R3: Opcode 0x00 with funct 0x20 (add), 0x22 (subtract), 0x24 (and), 0x25 (or) or 0x2A (signed set-less-than) takes 4 cycles and writes the result to the register named by bits [15:11] in its 4th cycle. Any other funct code except 0x3E acts as add.
- R4: A load (opcode 0x23) takes 5 cycles. It reads memory at rs + sign-extended bits [15:0] in cycle 4 and writes the read word to the register named by bits [20:16] in cycle 5.
- R5: A store (opcode 0x2B) takes 4 cycles. In cycle 4 it writes the register named by bits [20:16] to address rs + sign-extended offset.
- R6: Branch-on-equal (opcode 0x04) takes 3 cycles. When the registers in bits [25:21] and [20:16] are equal, the next fetch address is PC + 4 + (sign-extended offset × 4). Otherwise it is PC + 4.
- R7: Jump (opcode 0x02) takes 3 cycles. The next fetch address is the top 4 bits of PC + 4, followed by bits [25:0], followed by two zero bits.
- R8: The exchange is opcode 0x00 with funct 0x3E, encoded with the rs field equal to the rd field. It takes 4 cycles. Cycle 3 writes the old value of rt into rd, and cycle 4 writes the old value of rs into rt.
- R9: The three-operand add is opcode 0x3C, with rs in [25:21], rt in [20:16], rd in [15:11], bits [10:5] ignored and rx in [4:0]. It takes 5 cycles and writes rs + rt + rx (modulo 2^32) to rd in cycle 5, including the case where all three sources are the same register.
- R10: Register 0 always reads as zero. Writes that target it have no effect.
- R11: Any opcode not listed above takes 2 cycles (fetch and decode) and changes neither memory nor any register.
- R12: The memory port never reads and writes in the same cycle. Latch B changes only in the decode cycle and in the first execute cycle of the three-operand add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | XLEN | Byte address for memory |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | XLEN | Store data |
| mem_rdata | input | XLEN | Read data, valid in the same cycle as the address |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | $clog2(NREG) | Register file write index |
| rf_wdata_o | output | XLEN | Register file write data |
| pc_o | output | XLEN | Current program counter |

## Verification
Each result is tied to a cycle counted from the fetch of its instruction:
- The fetch read comes in cycle 1.
- A store's write and an arithmetic result come in cycle 4.
- A load's read comes in cycle 4 and its write-back in cycle 5.
- The exchange writes in cycles 3 and 4.
- The three-operand add writes in cycle 5.
- A branch or jump shows up as the address of the next fetch, one cycle after its third cycle.

At each fetch, a behavioural instruction model in the bench expands the instruction into a queue holding one expected port picture per cycle. The bench pops one entry on every falling edge, halfway between the edges where the registered control changes, so each result is checked in exactly the cycle it is due. The words the program finally stores are also compared against hand-computed constants.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_SUM3  = 6'h3C;

  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_XCHG = 6'h3E;

  // write-back data sources
  localparam logic [1:0] WSEL_OUT = 2'd0;
  localparam logic [1:0] WSEL_MDR = 2'd1;
  localparam logic [1:0] WSEL_A   = 2'd2;
  localparam logic [1:0] WSEL_B   = 2'd3;
  // ALU operand A sources
  localparam logic [1:0] ASEL_PC  = 2'd0;
  localparam logic [1:0] ASEL_A   = 2'd1;
  localparam logic [1:0] ASEL_OUT = 2'd2;
  // ALU operand B sources
  localparam logic [1:0] BSEL_B   = 2'd0;
  localparam logic [1:0] BSEL_4   = 2'd1;
  localparam logic [1:0] BSEL_IMM = 2'd2;
  localparam logic [1:0] BSEL_BR  = 2'd3;
  // ALU operation class
  localparam logic [1:0] AOP_ADD  = 2'd0;
  localparam logic [1:0] AOP_SUB  = 2'd1;
  localparam logic [1:0] AOP_FN   = 2'd2;
  // next PC sources
  localparam logic [1:0] PCSEL_ALU = 2'd0;
  localparam logic [1:0] PCSEL_OUT = 2'd1;
  localparam logic [1:0] PCSEL_JMP = 2'd2;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_MADDR, S_MREAD, S_MWB, S_MWRITE,
    S_REXEC, S_RWB, S_BRANCH, S_JUMP, S_XWB1, S_XWB2,
    S_S3EX1, S_S3EX2, S_S3WB
  } state_t;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       iord;
    logic       ir_we;
    logic       ld_ab;
    logic       write_b;
    logic       read_src;
    logic       rf_we;
    logic       dst_rd;
    logic [1:0] wsel;
    logic [1:0] asel;
    logic [1:0] bsel;
    logic [1:0] aop;
    logic       out_we;
    logic [1:0] pcsel;
    logic       pc_we;
    logic       pc_we_eq;
  } ctrl_t;

  function automatic ctrl_t state_controls(state_t s);
    ctrl_t c;
    c = '0;
    unique case (s)
      S_FETCH: begin
        c.mem_rd = 1'b1; c.ir_we = 1'b1;
        c.asel = ASEL_PC; c.bsel = BSEL_4; c.aop = AOP_ADD;
        c.pcsel = PCSEL_ALU; c.pc_we = 1'b1;
      end
      S_DECODE: begin
        c.ld_ab = 1'b1;
        c.asel = ASEL_PC; c.bsel = BSEL_BR; c.aop = AOP_ADD; c.out_we = 1'b1;
      end
      S_MADDR: begin
        c.asel = ASEL_A; c.bsel = BSEL_IMM; c.aop = AOP_ADD; c.out_we = 1'b1;
      end
      S_MREAD:  begin c.mem_rd = 1'b1; c.iord = 1'b1; end
      S_MWB:    begin c.rf_we = 1'b1; c.dst_rd = 1'b0; c.wsel = WSEL_MDR; end
      S_MWRITE: begin c.mem_wr = 1'b1; c.iord = 1'b1; end
      S_REXEC: begin
        c.asel = ASEL_A; c.bsel = BSEL_B; c.aop = AOP_FN; c.out_we = 1'b1;
      end
      S_RWB:    begin c.rf_we = 1'b1; c.dst_rd = 1'b1; c.wsel = WSEL_OUT; end
      S_BRANCH: begin
        c.asel = ASEL_A; c.bsel = BSEL_B; c.aop = AOP_SUB;
        c.pcsel = PCSEL_OUT; c.pc_we_eq = 1'b1;
      end
      S_JUMP:   begin c.pcsel = PCSEL_JMP; c.pc_we = 1'b1; end
      S_XWB1:   begin c.rf_we = 1'b1; c.dst_rd = 1'b1; c.wsel = WSEL_B; end
      S_XWB2:   begin c.rf_we = 1'b1; c.dst_rd = 1'b0; c.wsel = WSEL_A; end
      S_S3EX1: begin
        c.asel = ASEL_A; c.bsel = BSEL_B; c.aop = AOP_ADD; c.out_we = 1'b1;
        c.read_src = 1'b1; c.write_b = 1'b1;
      end
      S_S3EX2: begin
        c.asel = ASEL_OUT; c.bsel = BSEL_B; c.aop = AOP_ADD; c.out_we = 1'b1;
      end
      S_S3WB:   begin c.rf_we = 1'b1; c.dst_rd = 1'b1; c.wsel = WSEL_OUT; end
      default:  c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic [RAW-1:0] ra1,
  input  logic [RAW-1:0] ra2,
  output logic [W-1:0]   rd1,
  output logic [W-1:0]   rd2,
  input  logic           we,
  input  logic [RAW-1:0] wa,
  input  logic [W-1:0]   wd
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mc_alu.sv
module mc_alu import mc_pkg::*; #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   aop,
  input  logic [5:0]   funct,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (aop)
      AOP_SUB: y = a - b;
      AOP_FN: begin
        unique case (funct)
          FN_SUB:  y = a - b;
          FN_AND:  y = a & b;
          FN_OR:   y = a | b;
          FN_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
          default: y = a + b;
        endcase
      end
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl import mc_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output state_t     state,
  output ctrl_t      ctl
);
  state_t nxt;

  always_comb begin
    nxt = S_FETCH;
    unique case (state)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        unique case (opcode)
          OP_RTYPE: nxt = (funct == FN_XCHG) ? S_XWB1 : S_REXEC;
          OP_LOAD,
          OP_STORE: nxt = S_MADDR;
          OP_BEQ:   nxt = S_BRANCH;
          OP_JUMP:  nxt = S_JUMP;
          OP_SUM3:  nxt = S_S3EX1;
          default:  nxt = S_FETCH;
        endcase
      end
      S_MADDR:  nxt = (opcode == OP_LOAD) ? S_MREAD : S_MWRITE;
      S_MREAD:  nxt = S_MWB;
      S_REXEC:  nxt = S_RWB;
      S_XWB1:   nxt = S_XWB2;
      S_S3EX1:  nxt = S_S3EX2;
      S_S3EX2:  nxt = S_S3WB;
      default:  nxt = S_FETCH;
    endcase
  end

  // control outputs registered alongside the state: a Moore function of it
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      ctl   <= state_controls(S_FETCH);
    end else begin
      state <= nxt;
      ctl   <= state_controls(nxt);
    end
  end

  // R2
  fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
    state == S_FETCH |=> state == S_DECODE);
  // R8
  xchg_second_wb_chk: assert property (@(posedge clk) disable iff (rst)
    state == S_XWB1 |=> state == S_XWB2);
  // R8
  xchg_done_chk: assert property (@(posedge clk) disable iff (rst)
    state == S_XWB2 |=> state == S_FETCH);
  // R9
  sum3_second_ex_chk: assert property (@(posedge clk) disable iff (rst)
    state == S_S3EX1 |=> state == S_S3EX2);
  // R9
  sum3_wb_chk: assert property (@(posedge clk) disable iff (rst)
    state == S_S3EX2 |=> state == S_S3WB);
endmodule

// File: rtl/mc_core.sv
module mc_core import mc_pkg::*; #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            rf_we_o,
  output logic [RAW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic [XLEN-1:0] pc_o
);
  state_t state;
  ctrl_t  ctl;

  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, out_q, mdr_q;
  logic [XLEN-1:0] rd1, rd2, alu_a, alu_b, alu_y, pc_next, wdata;
  logic [XLEN-1:0] imm_ext, br_off;
  logic [RAW-1:0]  f_rs, f_rt, f_rd, f_rx, ra2, waddr;
  logic            alu_zero, pc_load;

  assign f_rs    = ir_q[21 +: RAW];
  assign f_rt    = ir_q[16 +: RAW];
  assign f_rd    = ir_q[11 +: RAW];
  assign f_rx    = ir_q[0  +: RAW];
  assign imm_ext = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign br_off  = {imm_ext[XLEN-3:0], 2'b00};

  mc_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (ir_q[31:26]),
    .funct  (ir_q[5:0]),
    .state  (state),
    .ctl    (ctl)
  );

  assign ra2   = ctl.read_src ? f_rx : f_rt;
  assign waddr = ctl.dst_rd ? f_rd : f_rt;

  always_comb begin
    unique case (ctl.wsel)
      WSEL_MDR: wdata = mdr_q;
      WSEL_A:   wdata = a_q;
      WSEL_B:   wdata = b_q;
      default:  wdata = out_q;
    endcase
  end

  mc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk (clk),
    .ra1 (f_rs),
    .ra2 (ra2),
    .rd1 (rd1),
    .rd2 (rd2),
    .we  (ctl.rf_we),
    .wa  (waddr),
    .wd  (wdata)
  );

  always_comb begin
    unique case (ctl.asel)
      ASEL_A:   alu_a = a_q;
      ASEL_OUT: alu_a = out_q;
      default:  alu_a = pc_q;
    endcase
    unique case (ctl.bsel)
      BSEL_4:   alu_b = XLEN'(4);
      BSEL_IMM: alu_b = imm_ext;
      BSEL_BR:  alu_b = br_off;
      default:  alu_b = b_q;
    endcase
  end

  mc_alu #(.W(XLEN)) u_alu (
    .a     (alu_a),
    .b     (alu_b),
    .aop   (ctl.aop),
    .funct (ir_q[5:0]),
    .y     (alu_y),
    .zero  (alu_zero)
  );

  always_comb begin
    unique case (ctl.pcsel)
      PCSEL_OUT: pc_next = out_q;
      PCSEL_JMP: pc_next = {pc_q[XLEN-1:28], ir_q[25:0], 2'b00};
      default:   pc_next = alu_y;
    endcase
  end

  assign pc_load = ctl.pc_we | (ctl.pc_we_eq & alu_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      out_q <= '0;
      mdr_q <= '0;
    end else begin
      mdr_q <= mem_rdata;
      if (pc_load)    pc_q  <= pc_next;
      if (ctl.ir_we)  ir_q  <= mem_rdata;
      if (ctl.out_we) out_q <= alu_y;
      if (ctl.ld_ab) begin
        a_q <= rd1;
        b_q <= rd2;
      end else if (ctl.write_b) begin
        b_q <= rd2;
      end
    end
  end

  assign mem_addr   = ctl.iord ? out_q : pc_q;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign mem_wdata  = b_q;
  assign rf_we_o    = ctl.rf_we;
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = wdata;
  assign pc_o       = pc_q;

  // R1
  rst_fetch_chk: assert property (@(posedge clk)
    $fell(rst) |-> (mem_rd && mem_addr == '0));
  // R12
  port_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr}));
  // R12
  b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl.ld_ab && !ctl.write_b) |=> $stable(b_q));
  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl.pc_we && !ctl.pc_we_eq) |=> $stable(pc_q));
endmodule

// File: tb/mc_core_test.sv
`timescale 1ns/1ps
module mc_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_wdata_o, pc_o;
  logic        mem_rd, mem_wr, rf_we_o;
  logic [4:0]  rf_waddr_o;

  always #2 clk = ~clk;

  mc_core uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .pc_o(pc_o)
  );

  logic [31:0] dmem [256];
  logic [31:0] mmem [256];
  logic [31:0] mreg [32];
  logic [31:0] mpc;

  assign mem_rdata = dmem[mem_addr[9:2]];
  always @(posedge clk) if (mem_wr) dmem[mem_addr[9:2]] <= mem_wdata;

  typedef struct {
    logic        rd, wr, rfwe;
    logic [31:0] addr, wdata, wd;
    logic [4:0]  wa;
    string       tag;
  } exp_t;
  exp_t expq[$];

  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_s3(int rs, int rt, int rd, int rx);
    return {6'h3C, 5'(rs), 5'(rt), 5'(rd), 6'd0, 5'(rx)};
  endfunction

  task automatic push(logic rd, logic wr, logic [31:0] addr, logic [31:0] wdata,
                      logic rfwe, logic [4:0] wa, logic [31:0] wd, string tag);
    exp_t e;
    e.rd = rd; e.wr = wr; e.addr = addr; e.wdata = wdata;
    e.rfwe = rfwe; e.wa = wa; e.wd = wd; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic idle(string tag);
    push(1'b0, 1'b0, '0, '0, 1'b0, '0, '0, tag);
  endtask

  task automatic mwrite(int r, logic [31:0] v);
    if (r != 0) mreg[r] = v;
  endtask

  // behavioural model: one instruction expands into one expected entry per cycle
  task automatic model_step();
    logic [31:0] ins, sx, ea, res, va, vb;
    int rs, rt, rd, rx;
    ins = mmem[mpc[9:2]];
    push(1'b1, 1'b0, mpc, '0, 1'b0, '0, '0, "R2");
    idle("R2");
    mpc = mpc + 4;
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]); rx = int'(ins[4:0]);
    sx = {{16{ins[15]}}, ins[15:0]};
    va = mreg[rs]; vb = mreg[rt];
    case (ins[31:26])
      6'h00: begin
        if (ins[5:0] == 6'h3E) begin
          push(1'b0, 1'b0, '0, '0, 1'b1, 5'(rd), vb, "R8");
          push(1'b0, 1'b0, '0, '0, 1'b1, 5'(rt), va, "R8");
          mwrite(rd, vb);
          mwrite(rt, va);
        end else begin
          case (ins[5:0])
            6'h22:   res = va - vb;
            6'h24:   res = va & vb;
            6'h25:   res = va | vb;
            6'h2A:   res = ($signed(va) < $signed(vb)) ? 32'd1 : 32'd0;
            default: res = va + vb;
          endcase
          idle("R3");
          push(1'b0, 1'b0, '0, '0, 1'b1, 5'(rd), res, "R3");
          mwrite(rd, res);
        end
      end
      6'h23: begin
        ea = va + sx;
        idle("R4");
        push(1'b1, 1'b0, ea, '0, 1'b0, '0, '0, "R4");
        push(1'b0, 1'b0, '0, '0, 1'b1, 5'(rt), mmem[ea[9:2]], "R4");
        mwrite(rt, mmem[ea[9:2]]);
      end
      6'h2B: begin
        ea = va + sx;
        idle("R5");
        push(1'b0, 1'b1, ea, vb, 1'b0, '0, '0, "R5");
        mmem[ea[9:2]] = vb;
      end
      6'h04: begin
        idle("R6");
        if (va == vb) mpc = mpc + {sx[29:0], 2'b00};
      end
      6'h02: begin
        idle("R7");
        mpc = {mpc[31:28], ins[25:0], 2'b00};
      end
      6'h3C: begin
        res = va + vb + mreg[rx];
        idle("R9");
        idle("R9");
        push(1'b0, 1'b0, '0, '0, 1'b1, 5'(rd), res, (rd == 0) ? "R10" : "R9");
        mwrite(rd, res);
      end
      default: ; // R11: fetch and decode only
    endcase
  endtask

  task automatic compare(exp_t e);
    bit ok;
    checks++;
    ok = (mem_rd === e.rd) && (mem_wr === e.wr) && (rf_we_o === e.rfwe);
    if (e.rd || e.wr) ok = ok && (mem_addr === e.addr);
    if (e.wr)         ok = ok && (mem_wdata === e.wdata);
    if (e.rfwe)       ok = ok && (rf_waddr_o === e.wa) && (rf_wdata_o === e.wd);
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual rd=%0b wr=%0b addr=%h wdata=%h we=%0b wa=%0d wd=%h expected rd=%0b wr=%0b addr=%h wdata=%h we=%0b wa=%0d wd=%h",
               e.tag, mem_rd, mem_wr, mem_addr, mem_wdata, rf_we_o, rf_waddr_o, rf_wdata_o,
               e.rd, e.wr, e.addr, e.wdata, e.rfwe, e.wa, e.wd);
    end
  endtask

  task automatic check_word(int addr, logic [31:0] exp, string tag);
    checks++;
    if (dmem[addr >> 2] !== exp) begin
      fails++;
      $display("FAIL %s: word %h actual %h expected %h", tag, addr, dmem[addr >> 2], exp);
    end
  endtask

  task automatic load_program();
    logic [31:0] p [29];
    p[0]  = enc_i(6'h23, 0, 1, 'h200);     // r1 = 7
    p[1]  = enc_i(6'h23, 0, 2, 'h204);     // r2 = 5
    p[2]  = enc_i(6'h23, 0, 3, 'h208);     // r3 = 100
    p[3]  = enc_r(1, 2, 4, 6'h20);         // R3 add -> 12
    p[4]  = enc_r(2, 1, 5, 6'h22);         // R3 sub -> -2
    p[5]  = enc_r(5, 1, 7, 6'h2A);         // R3 slt signed -> 1
    p[6]  = enc_r(1, 3, 8, 6'h25);         // R3 or
    p[7]  = enc_r(1, 2, 9, 6'h24);         // R3 and
    p[8]  = enc_s3(1, 2, 10, 3);           // R9 -> 112
    p[9]  = enc_s3(4, 4, 11, 4);           // R9 same source thrice -> 36
    p[10] = enc_s3(1, 2, 0, 3);            // R10 write to r0 ignored
    p[11] = enc_r(1, 2, 1, 6'h3E);         // R8 swap r1,r2
    p[12] = enc_r(3, 3, 3, 6'h3E);         // R8 swap a register with itself
    p[13] = 32'hFC00_0000;                 // R11 unknown opcode
    p[14] = enc_i(6'h04, 1, 2, 1);         // R6 not taken
    p[15] = enc_i(6'h04, 4, 4, 1);         // R6 taken, skips next
    p[16] = enc_r(1, 1, 12, 6'h20);        // skipped
    p[17] = enc_i(6'h23, 0, 13, 'h20C);    // r13 = 1
    p[18] = enc_i(6'h23, 0, 14, 'h210);    // r14 = 3
    p[19] = enc_i(6'h04, 14, 0, 2);        // loop exit
    p[20] = enc_r(14, 13, 14, 6'h22);
    p[21] = {6'h02, 26'd19};               // R7 backward jump
    p[22] = enc_i(6'h2B, 0, 10, 'h280);
    p[23] = enc_i(6'h2B, 0, 1, 'h284);
    p[24] = enc_i(6'h2B, 0, 2, 'h288);
    p[25] = enc_i(6'h2B, 0, 11, 'h28C);
    p[26] = enc_i(6'h2B, 0, 0, 'h290);
    p[27] = enc_i(6'h2B, 0, 5, 'h294);
    p[28] = {6'h02, 26'd28};               // halt loop
    for (int i = 0; i < 256; i++) dmem[i] = '0;
    for (int i = 0; i < 29; i++) dmem[i] = p[i];
    dmem[128] = 32'd7; dmem[129] = 32'd5; dmem[130] = 32'd100;
    dmem[131] = 32'd1; dmem[132] = 32'd3;
    for (int i = 0; i < 256; i++) mmem[i] = dmem[i];
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    mpc = '0;
  endtask

  initial begin
    load_program();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    // R1: no writes while in reset
    checks++;
    if (mem_wr !== 1'b0 || rf_we_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: actual wr=%0b we=%0b expected wr=0 we=0", mem_wr, rf_we_o);
    end
    rst = 1'b0;
    for (int c = 0; c < 600; c++) begin
      if (expq.size() == 0) model_step();
      compare(expq.pop_front());
      @(negedge clk);
    end
    check_word('h280, 32'd112, "R9");
    check_word('h28C, 32'd36, "R9");
    check_word('h284, 32'd5, "R8");
    check_word('h288, 32'd7, "R8");
    check_word('h290, 32'd0, "R10");
    check_word('h294, 32'hFFFF_FFFE, "R3");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2: watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule